// File: doc/BRIEF.md
# Queued Serial Peripheral Master

This block is a memory-mapped SPI master that works through a batch of up to sixteen serial words with no processor help. Transmit words, receive words and per-entry control bits live in three sixteen-entry internal stores. Software reaches all three through one pointer register and one data port, and the pointer advances by one on every data access. Software first programs the clock polarity and phase, the word size and the baud divisor. It then writes a start and an end index and sets a run bit. The sequencer shifts every entry from the start index to the end index and files each received word at the same index it was sent from. It then clears the run bit and raises a completion flag, which can drive an interrupt.

A batch can run in a loop (wrap), can be halted after the current entry, and can insert a fixed gap after chosen entries. A single chip-select output follows the entries, with a programmable inactive level. Any write that would corrupt the live window while a batch runs is dropped and flagged.

Top module: `qspi_queue_master`

## Requirements
- R1: Register offsets are mode 0x00, run 0x04, queue control 0x08, interrupt 0x0C, pointer 0x10 and data 0x14. The pointer (6 bits) selects transmit entries 0x00–0x0F, receive entries 0x10–0x1F or control entries 0x20–0x2F. Each read or write of the data register acts on the selected entry and then adds one to the pointer. Bus writes to receive entries are dropped.
- R2: SCK toggles once every D system clocks, where D is the divisor in mode bits 7:0 (D = 1 acts as 2). With D = 0, no SCK edge occurs and a started batch waits until the divisor becomes nonzero.
- R3: Mode bits 13:10 give the word size when they hold 8 to 15, and any other value means 16 bits. An entry whose control bit 14 is clear uses 8 bits. Words leave MSB first. Each received word is stored right-justified with zero upper bits, at the receive index equal to its transmit index.
- R4: Writing 1 to run bit 15 while idle starts at the start index (queue control bits 3:0) and runs through the end index (bits 11:8), passing from 15 to 0 when start > end. Bit 15 reads 1 until the last entry completes.
- R5: Interrupt bit 0 (finish) is set when the end-index entry completes. Flags at bits 0, 2 and 3 clear when written with 1. Their enables sit at bits 8, 10 and 11. `irq` is the OR of each flag ANDed with its enable.
- R6: When no word is in flight, SCK rests at CPOL (mode bit 9). With CPHA (mode bit 8) clear, MISO is sampled on the leading edge of each bit. With CPHA set, MISO is sampled on the trailing edge.
- R7: `cs_o` sits at the inactive level (queue control bit 12) when idle and at the opposite level during an entry. It stays active into the next entry only when the entry's control bit 15 is set.
- R8: An entry with control bit 13 set adds exactly DLY_CYCLES system clocks after its last SCK edge.
- R9: With halt (queue control bit 15) set, the batch stops after the current entry, sets abort flag bit 2 and clears the run bit.
- R10: With wrap (queue control bit 14) set, the batch restarts at the start index after the end index and sets finish on every pass. Writing 0 to the run bit stops it at the next entry boundary.
- R11: While a batch runs, a data-register write to a transmit or control entry whose index lies inside the start..end window is dropped and sets collision flag bit 3. The pointer still advances.
- R12: After reset, mode, interrupt and run registers read 0, so the divisor is 0 and the size is 16 bits. `irq`, `sck` and `cs_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select for the running batch |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DLY_CYCLES set to 6, so the gap check can compare two runs that differ only in the control bit and expect the difference to be exactly six cycles. The serial side is an inverting loopback, so every received word is the complement of the sent word masked to the active size. Any one-edge slip between MOSI update and MISO sample shows up as a wrong received value. Divisors of 0, 2, 3, 5 and 20 cover the stall path, the minimum half-period and runs long enough for writes to land mid-batch.

// File: rtl/qsm_pkg.sv
// Shared sizes, sequencer state type and window test for the queued SPI master.
// Assumes a queue depth that is a power of two and matches the 4-bit index fields.
package qsm_pkg;
    localparam int WORD_W  = 16;
    localparam int QDEPTH  = 16;
    localparam int IDX_W   = $clog2(QDEPTH);
    localparam int PTR_W   = IDX_W + 2;
    localparam int DIV_W   = 8;
    localparam int NB_W    = $clog2(WORD_W) + 1;

    typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_SHIFT, SQ_GAP} seq_state_t;

    // True when idx lies in the circular window first..last.
    function automatic logic in_window(input logic [IDX_W-1:0] idx,
                                       input logic [IDX_W-1:0] first,
                                       input logic [IDX_W-1:0] last);
        if (first <= last)
            return (idx >= first) && (idx <= last);
        else
            return (idx >= first) || (idx <= last);
    endfunction
endpackage

// File: rtl/qsm_baud.sv
// Half-period timer for SCK: pulses tick once every div clocks while run is high.
// Assumes div is nonzero when run is high; values below 2 act as 2.
module qsm_baud
    import qsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
    assign tick    = run && (cnt_q == '0);

    // Count down one half-period and reload on each tick or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= div_eff - DIV_W'(1);
        else if (run)
            cnt_q <= cnt_q - DIV_W'(1);
    end
endmodule

// File: rtl/qsm_shifter.sv
// Serial word engine: shifts nbits MSB first with the chosen clock mode and
// collects the received bits right-justified. Assumes 8 <= nbits <= WORD_W.
module qsm_shifter
    import qsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [NB_W-1:0]   nbits,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              active,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi
);
    logic [WORD_W-1:0] txsh_q;
    logic [WORD_W-1:0] rxsh_q;
    logic [NB_W-1:0]   nb_q;
    logic [NB_W:0]     edges_q;
    logic              ph_q;
    logic              sck_q;
    logic              mosi_q;
    logic              lead;
    logic              last_edge;

    assign lead      = ~edges_q[0];
    assign last_edge = (edges_q == ({nb_q, 1'b0} - (NB_W+1)'(1)));
    assign sck       = active ? sck_q : cpol;
    assign mosi      = mosi_q;
    assign rx_word   = rxsh_q;

    // Load a word on start, then move one SCK edge per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            done    <= 1'b0;
            txsh_q  <= '0;
            rxsh_q  <= '0;
            nb_q    <= NB_W'(WORD_W);
            edges_q <= '0;
            ph_q    <= 1'b0;
            sck_q   <= 1'b0;
            mosi_q  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                edges_q <= '0;
                nb_q    <= nbits;
                ph_q    <= cpha;
                sck_q   <= cpol;
                rxsh_q  <= '0;
                txsh_q  <= tx_word << (NB_W'(WORD_W) - nbits);
                mosi_q  <= cpha ? 1'b0 : tx_word[4'(nbits - NB_W'(1))];
            end else if (active && tick) begin
                sck_q   <= ~sck_q;
                edges_q <= edges_q + (NB_W+1)'(1);
                if (lead ^ ph_q) begin
                    rxsh_q <= {rxsh_q[WORD_W-2:0], miso};
                end else if (lead) begin
                    mosi_q <= txsh_q[WORD_W-1];
                    txsh_q <= txsh_q << 1;
                end else begin
                    mosi_q <= txsh_q[WORD_W-2];
                    txsh_q <= txsh_q << 1;
                end
                if (last_edge) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rx_word >> nb_q) == '0)); // R3
    AST_DONE_ENDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active && $past(active))); // R2
endmodule

// File: rtl/qsm_sequencer.sv
// Queue walker: steps the entry index from start to end, starts the shifter,
// stores results, applies gap, halt, wrap and stop, and owns the run bit.
// Assumes the window pointers stay constant while a batch runs.
module qsm_sequencer
    import qsm_pkg::*;
#(
    parameter int DLY_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             stop_req,
    input  logic             halt,
    input  logic             wrap,
    input  logic [IDX_W-1:0] start_ptr,
    input  logic [IDX_W-1:0] end_ptr,
    input  logic             div_zero,
    input  logic             cmd_cont,
    input  logic             cmd_gap,
    input  logic             sh_done,
    output logic             running,
    output logic [IDX_W-1:0] qidx,
    output logic             sh_start,
    output logic             rx_we,
    output logic             cs_act,
    output logic             set_fin,
    output logic             set_abrt
);
    localparam int DLY_W = $clog2(DLY_CYCLES + 1);

    seq_state_t       state_q;
    logic [DLY_W-1:0] dcnt_q;
    logic             cont_q;
    logic             gap_q;
    logic             stop_pend_q;
    logic             entry_end;
    logic             at_end;
    logic             stop_now;

    assign at_end    = (qidx == end_ptr);
    assign sh_start  = (state_q == SQ_LOAD) && !div_zero;
    assign rx_we     = (state_q == SQ_SHIFT) && sh_done;
    assign entry_end = ((state_q == SQ_SHIFT) && sh_done && !gap_q)
                     || ((state_q == SQ_GAP) && (dcnt_q == '0));
    assign stop_now  = halt || stop_pend_q || (at_end && !wrap);
    assign set_fin   = entry_end && !halt && at_end;
    assign set_abrt  = entry_end && halt;

    // Walk the queue one entry at a time and decide at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SQ_IDLE;
            running     <= 1'b0;
            qidx        <= '0;
            dcnt_q      <= '0;
            cont_q      <= 1'b0;
            gap_q       <= 1'b0;
            stop_pend_q <= 1'b0;
            cs_act      <= 1'b0;
        end else begin
            if (stop_req)
                stop_pend_q <= 1'b1;
            case (state_q)
                SQ_IDLE: if (go) begin
                    running     <= 1'b1;
                    qidx        <= start_ptr;
                    stop_pend_q <= 1'b0;
                    state_q     <= SQ_LOAD;
                end
                SQ_LOAD: if (!div_zero) begin
                    cont_q  <= cmd_cont;
                    gap_q   <= cmd_gap;
                    cs_act  <= 1'b1;
                    state_q <= SQ_SHIFT;
                end
                SQ_SHIFT: if (sh_done && gap_q) begin
                    dcnt_q  <= DLY_W'(DLY_CYCLES - 1);
                    state_q <= SQ_GAP;
                end
                SQ_GAP: if (dcnt_q != '0)
                    dcnt_q <= dcnt_q - DLY_W'(1);
                default: state_q <= SQ_IDLE;
            endcase
            if (entry_end) begin
                if (stop_now) begin
                    running <= 1'b0;
                    cs_act  <= 1'b0;
                    state_q <= SQ_IDLE;
                end else begin
                    qidx    <= at_end ? start_ptr : qidx + IDX_W'(1);
                    state_q <= SQ_LOAD;
                    if (!cont_q)
                        cs_act <= 1'b0;
                end
            end
        end
    end

    AST_RX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> in_window(qidx, start_ptr, end_ptr)); // R4
    AST_CS_DROP_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> !cs_act); // R7
endmodule

// File: rtl/qspi_queue_master.sv
// Queued SPI master top: register file, three entry stores, pointer/data port,
// interrupt flags, and the sequencer, baud timer and shifter beneath them.
// Assumes one register access per reg_en cycle; reads are side-effect free
// except the data register, whose access advances the pointer.
module qspi_queue_master
    import qsm_pkg::*;
#(
    parameter int DLY_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_o,
    output logic        irq
);
    localparam logic [4:0] OFS_MODE = 5'h00;
    localparam logic [4:0] OFS_RUN  = 5'h04;
    localparam logic [4:0] OFS_QCTL = 5'h08;
    localparam logic [4:0] OFS_INT  = 5'h0C;
    localparam logic [4:0] OFS_PTR  = 5'h10;
    localparam logic [4:0] OFS_DATA = 5'h14;
    localparam logic [1:0] BANK_TX  = 2'd0;
    localparam logic [1:0] BANK_RX  = 2'd1;
    localparam logic [1:0] BANK_CMD = 2'd2;

    logic             mode_mstr, mode_cpol, mode_cpha;
    logic [3:0]       mode_size;
    logic [DIV_W-1:0] mode_div;
    logic             halt_q, wrap_q, csiv_q;
    logic [IDX_W-1:0] end_q, start_q;
    logic             en_fin, en_abrt, en_coll;
    logic             fl_fin, fl_abrt, fl_coll;
    logic [PTR_W-1:0] ptr_q;

    logic [WORD_W-1:0] tx_ram [QDEPTH];
    logic [WORD_W-1:0] rx_ram [QDEPTH];
    logic [2:0]        cmd_ram [QDEPTH];

    logic             wr, data_acc, data_wr, win_hit, coll_set;
    logic             tx_wr, cmd_wr, go, stop_req;
    logic [1:0]       ptr_bank;
    logic [IDX_W-1:0] ptr_idx;
    logic [NB_W-1:0]  mode_nbits, sh_nbits;
    logic [2:0]       cmd_cur;

    logic             running, sh_start, rx_we, cs_act, set_fin, set_abrt;
    logic [IDX_W-1:0] qidx;
    logic             tick, sh_active, sh_done;
    logic [WORD_W-1:0] sh_rx;
    logic             div_zero;

    assign wr       = reg_en && reg_we;
    assign data_acc = reg_en && (reg_addr == OFS_DATA);
    assign data_wr  = wr && (reg_addr == OFS_DATA);
    assign ptr_bank = ptr_q[PTR_W-1:IDX_W];
    assign ptr_idx  = ptr_q[IDX_W-1:0];
    assign win_hit  = running && in_window(ptr_idx, start_q, end_q);
    assign coll_set = data_wr && win_hit && ((ptr_bank == BANK_TX) || (ptr_bank == BANK_CMD));
    assign tx_wr    = data_wr && (ptr_bank == BANK_TX) && !win_hit;
    assign cmd_wr   = data_wr && (ptr_bank == BANK_CMD) && !win_hit;
    assign go       = wr && (reg_addr == OFS_RUN) && reg_wdata[15] && !running;
    assign stop_req = wr && (reg_addr == OFS_RUN) && !reg_wdata[15] && running;

    assign div_zero   = (mode_div == '0);
    assign mode_nbits = mode_size[3] ? NB_W'(mode_size) : NB_W'(WORD_W);
    assign cmd_cur    = cmd_ram[qidx];
    assign sh_nbits   = cmd_cur[1] ? mode_nbits : NB_W'(8);

    assign cs_o = cs_act ? ~csiv_q : csiv_q;
    assign irq  = (fl_fin & en_fin) | (fl_abrt & en_abrt) | (fl_coll & en_coll);

    // Mode register: master bit, word size, clock mode and divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_mstr <= 1'b0; mode_size <= '0; mode_cpol <= 1'b0;
            mode_cpha <= 1'b0; mode_div  <= '0;
        end else if (wr && (reg_addr == OFS_MODE)) begin
            mode_mstr <= reg_wdata[15];
            mode_size <= reg_wdata[13:10];
            mode_cpol <= reg_wdata[9];
            mode_cpha <= reg_wdata[8];
            mode_div  <= reg_wdata[DIV_W-1:0];
        end
    end

    // Queue control register: halt, wrap, chip-select level and window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0; wrap_q <= 1'b0; csiv_q <= 1'b0;
            end_q  <= '0;   start_q <= '0;
        end else if (wr && (reg_addr == OFS_QCTL)) begin
            halt_q  <= reg_wdata[15];
            wrap_q  <= reg_wdata[14];
            csiv_q  <= reg_wdata[12];
            end_q   <= reg_wdata[8 +: IDX_W];
            start_q <= reg_wdata[0 +: IDX_W];
        end
    end

    // Interrupt enables and write-one-to-clear status flags; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_fin <= 1'b0; en_abrt <= 1'b0; en_coll <= 1'b0;
            fl_fin <= 1'b0; fl_abrt <= 1'b0; fl_coll <= 1'b0;
        end else begin
            if (wr && (reg_addr == OFS_INT)) begin
                en_fin  <= reg_wdata[8];
                en_abrt <= reg_wdata[10];
                en_coll <= reg_wdata[11];
            end
            fl_fin  <= set_fin  | (fl_fin  & ~(wr && (reg_addr == OFS_INT) && reg_wdata[0]));
            fl_abrt <= set_abrt | (fl_abrt & ~(wr && (reg_addr == OFS_INT) && reg_wdata[2]));
            fl_coll <= coll_set | (fl_coll & ~(wr && (reg_addr == OFS_INT) && reg_wdata[3]));
        end
    end

    // Address pointer: loaded by write, advanced by each data access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (wr && (reg_addr == OFS_PTR))
            ptr_q <= reg_wdata[PTR_W-1:0];
        else if (data_acc)
            ptr_q <= ptr_q + PTR_W'(1);
    end

    // Transmit store: bus writes outside the live window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QDEPTH; i++) tx_ram[i] <= '0;
        end else if (tx_wr) begin
            tx_ram[ptr_idx] <= reg_wdata;
        end
    end

    // Control store: keeps only continue, size-select and gap bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QDEPTH; i++) cmd_ram[i] <= '0;
        end else if (cmd_wr) begin
            cmd_ram[ptr_idx] <= reg_wdata[15:13];
        end
    end

    // Receive store: written only by the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QDEPTH; i++) rx_ram[i] <= '0;
        end else if (rx_we) begin
            rx_ram[qidx] <= sh_rx;
        end
    end

    // Read mux for the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MODE: reg_rdata = {mode_mstr, 1'b0, mode_size, mode_cpol, mode_cpha, mode_div};
            OFS_RUN:  reg_rdata = {running, 15'b0};
            OFS_QCTL: reg_rdata = {halt_q, wrap_q, 1'b0, csiv_q, end_q, qidx, start_q};
            OFS_INT:  reg_rdata = {4'b0, en_coll, en_abrt, 1'b0, en_fin,
                                   4'b0, fl_coll, fl_abrt, 1'b0, fl_fin};
            OFS_PTR:  reg_rdata = {{(16-PTR_W){1'b0}}, ptr_q};
            OFS_DATA: begin
                case (ptr_bank)
                    BANK_TX:  reg_rdata = tx_ram[ptr_idx];
                    BANK_RX:  reg_rdata = rx_ram[ptr_idx];
                    BANK_CMD: reg_rdata = {cmd_ram[ptr_idx], 13'b0};
                    default:  reg_rdata = '0;
                endcase
            end
            default: reg_rdata = '0;
        endcase
    end

    qsm_sequencer #(.DLY_CYCLES(DLY_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .stop_req(stop_req),
        .halt(halt_q), .wrap(wrap_q), .start_ptr(start_q), .end_ptr(end_q),
        .div_zero(div_zero), .cmd_cont(cmd_cur[2]), .cmd_gap(cmd_cur[0]),
        .sh_done(sh_done), .running(running), .qidx(qidx), .sh_start(sh_start),
        .rx_we(rx_we), .cs_act(cs_act), .set_fin(set_fin), .set_abrt(set_abrt)
    );

    qsm_baud u_baud (
        .clk(clk), .rst_n(rst_n), .restart(sh_start), .run(sh_active),
        .div(mode_div), .tick(tick)
    );

    qsm_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tick(tick),
        .nbits(sh_nbits), .cpol(mode_cpol), .cpha(mode_cpha),
        .tx_word(tx_ram[qidx]), .miso(miso), .active(sh_active),
        .done(sh_done), .rx_word(sh_rx), .sck(sck), .mosi(mosi)
    );

    AST_NO_SHIFT_WHILE_DIV0: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> !sh_start); // R2
    AST_FIN_STOPS_BATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fl_fin) && !wrap_q && !halt_q) |-> !running); // R5
endmodule

// File: tb/sim_qspi_queue_master.sv
module sim_qspi_queue_master;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sck, mosi, miso, cs_o, irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    assign miso = ~mosi;

    qspi_queue_master #(.DLY_CYCLES(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Serial-side monitor: SCK rises, shortest half-period, chip-select assertions.
    int   rises = 0, cs_asserts = 0, since = 0, min_half = 1000;
    logic sck_d = 1'b0, cs_d = 1'b0, mon_clr = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        sck_d <= sck;
        cs_d  <= cs_o;
        if (mon_clr) begin
            rises <= 0; cs_asserts <= 0; since <= 1; min_half <= 1000;
        end else begin
            if (sck && !sck_d) rises <= rises + 1;
            if (cs_d && !cs_o) cs_asserts <= cs_asserts + 1;
            if (sck != sck_d) begin
                if (since < min_half) min_half <= since;
                since <= 1;
            end else begin
                since <= since + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clr_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_en = 1'b0;
    endtask

    task automatic load_entry(input int idx, input logic [15:0] cmd, input logic [15:0] tx);
        wr(5'h10, 16'(idx));
        wr(5'h14, tx);
        wr(5'h10, 16'(32 + idx));
        wr(5'h14, cmd);
    endtask

    task automatic rd_entry(input int bank_base, input int idx, output logic [15:0] d);
        wr(5'h10, 16'(bank_base + idx));
        rd(5'h14, d);
    endtask

    // Holds a read of the run register and counts cycles until bit 15 drops.
    task automatic wait_idle(output int n);
        n = 0;
        @(negedge clk); reg_en = 1'b1; reg_we = 1'b0; reg_addr = 5'h04;
        #1;
        while (reg_rdata[15] && n < 5000) begin
            @(negedge clk); #1; n++;
        end
        reg_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(5'h00, d); check("R12", "mode after reset", d, 0);
        rd(5'h0C, d); check("R12", "interrupt reg after reset", d, 0);
        rd(5'h04, d); check("R12", "run bit after reset", d, 0);
        check("R12", "irq/sck/cs after reset", {irq, sck, cs_o}, 0);
    endtask

    task automatic t_port();
        logic [15:0] d;
        wr(5'h10, 16'h0003);
        wr(5'h14, 16'hABCD);
        wr(5'h14, 16'h1357);
        rd(5'h10, d); check("R1", "pointer after two data writes", d, 5);
        wr(5'h10, 16'h0003);
        rd(5'h14, d); check("R1", "tx entry 3", d, 16'hABCD);
        rd(5'h14, d); check("R1", "tx entry 4 via auto-advance", d, 16'h1357);
        wr(5'h10, 16'h0012);
        wr(5'h14, 16'h1234);
        rd_entry(16, 2, d); check("R1", "rx entry write dropped", d, 0);
    endtask

    task automatic t_basic8();
        logic [15:0] d;
        int n;
        logic [7:0] txv [3] = '{8'h5A, 8'h3C, 8'hFF};
        wr(5'h00, 16'hA002);
        for (int i = 0; i < 3; i++) load_entry(i, 16'h4000, {8'h00, txv[i]});
        wr(5'h08, 16'h0200);
        wr(5'h0C, 16'h0100);
        clr_mon();
        wr(5'h04, 16'h8000);
        rd(5'h04, d); check("R4", "run bit while busy", d[15], 1);
        wait_idle(n);
        check("R4", "run bit clears at end", (n < 5000), 1);
        check("R3", "SCK rises for three 8-bit words", rises, 24);
        check("R2", "half-period at divisor 2", min_half, 2);
        for (int i = 0; i < 3; i++) begin
            rd_entry(16, i, d);
            check("R3", $sformatf("rx entry %0d (8-bit, same index)", i), d, {8'h00, ~txv[i]});
        end
        rd(5'h0C, d); check("R5", "finish flag set", d[0], 1);
        check("R5", "irq with finish enabled", irq, 1);
        wr(5'h0C, 16'h0101);
        rd(5'h0C, d); check("R5", "finish flag cleared by W1C", d[0], 0);
        check("R5", "irq after clear", irq, 0);
    endtask

    task automatic t_mode16();
        logic [15:0] d;
        int n;
        wr(5'h00, 16'h8305);
        check("R6", "SCK idle level follows CPOL=1", sck, 1);
        load_entry(4, 16'h4000, 16'hA5C3);
        load_entry(5, 16'h0000, 16'h1234);
        wr(5'h08, 16'h0504);
        clr_mon();
        wr(5'h04, 16'h8000);
        wait_idle(n);
        check("R3", "SCK rises for 16+8 bits", rises, 24);
        check("R2", "half-period at divisor 5", min_half, 5);
        rd_entry(16, 4, d); check("R6", "rx 16-bit, CPHA=1 CPOL=1", d, 16'h5A3C);
        rd_entry(16, 5, d); check("R3", "control bit 14 clear gives 8 bits", d, 16'h00CB);
        check("R6", "SCK back at idle CPOL", sck, 1);
    endtask

    task automatic t_wrapwin();
        logic [15:0] d;
        int n;
        wr(5'h00, 16'hB003);
        load_entry(15, 16'h4000, 16'h0ABC);
        load_entry(0, 16'h4000, 16'h0123);
        wr(5'h08, 16'h000F);
        clr_mon();
        wr(5'h04, 16'h8000);
        wait_idle(n);
        check("R4", "window 15..0 passes two 12-bit words", rises, 24);
        rd_entry(16, 15, d); check("R3", "rx entry 15 (12-bit)", d, 16'h0543);
        rd_entry(16, 0, d); check("R4", "rx entry 0 after index wrap", d, 16'h0EDC);
        wr(5'h0C, 16'h000D);
    endtask

    task automatic t_cs();
        int n;
        wr(5'h00, 16'hA002);
        load_entry(0, 16'hC000, 16'h0011);
        load_entry(1, 16'h4000, 16'h0022);
        load_entry(2, 16'h4000, 16'h0033);
        wr(5'h08, 16'h1200);
        check("R7", "cs_o idle at inactive level 1", cs_o, 1);
        clr_mon();
        wr(5'h04, 16'h8000);
        wait_idle(n);
        check("R7", "cs assertions with continue on entry 0", cs_asserts, 2);
        check("R7", "cs_o back inactive", cs_o, 1);
        wr(5'h08, 16'h0000);
        wr(5'h0C, 16'h000D);
    endtask

    task automatic t_gap();
        int n1, n2;
        load_entry(0, 16'h4000, 16'h0055);
        wr(5'h04, 16'h8000);
        wait_idle(n1);
        load_entry(0, 16'h6000, 16'h0055);
        wr(5'h04, 16'h8000);
        wait_idle(n2);
        check("R8", "gap adds DLY_CYCLES clocks", n2 - n1, GAP);
        wr(5'h0C, 16'h000D);
    endtask

    task automatic t_halt();
        logic [15:0] d;
        int n;
        for (int i = 0; i < 4; i++) load_entry(i, 16'h4000, 16'(i));
        wr(5'h08, 16'h8300);
        wr(5'h0C, 16'h0400);
        clr_mon();
        wr(5'h04, 16'h8000);
        wait_idle(n);
        check("R9", "halt stops after one entry", rises, 8);
        rd(5'h0C, d);
        check("R9", "abort flag set, finish clear", {d[2], d[0]}, 2'b10);
        check("R9", "irq from abort", irq, 1);
        rd(5'h04, d); check("R9", "run bit cleared by halt", d[15], 0);
        wr(5'h0C, 16'h000D);
        wr(5'h08, 16'h0000);
    endtask

    task automatic t_loop();
        logic [15:0] d;
        int passes = 0, n;
        load_entry(0, 16'h4000, 16'h0081);
        load_entry(1, 16'h4000, 16'h0018);
        wr(5'h08, 16'h4100);
        clr_mon();
        wr(5'h04, 16'h8000);
        for (int k = 0; k < 2; k++) begin
            n = 0;
            d = '0;
            while (!d[0] && n < 2000) begin rd(5'h0C, d); n++; end
            if (d[0]) passes++;
            wr(5'h0C, 16'h0001);
        end
        check("R10", "finish raised on two passes", passes, 2);
        rd(5'h04, d); check("R10", "still running under wrap", d[15], 1);
        wr(5'h04, 16'h0000);
        wait_idle(n);
        check("R10", "stops after software clear", (n < 5000), 1);
        check("R10", "whole words only, at least two passes", (rises >= 32) && (rises % 8 == 0), 1);
        wr(5'h08, 16'h0000);
        wr(5'h0C, 16'h000D);
    endtask

    task automatic t_collision();
        logic [15:0] d;
        int n;
        wr(5'h00, 16'h8014);
        load_entry(0, 16'h4000, 16'h1111);
        load_entry(1, 16'h4000, 16'h2222);
        load_entry(8, 16'h4000, 16'h0000);
        wr(5'h08, 16'h0100);
        wr(5'h0C, 16'h0800);
        wr(5'h04, 16'h8000);
        wr(5'h10, 16'h0000);
        wr(5'h14, 16'hDEAD);
        rd(5'h10, d); check("R11", "pointer advances on dropped write", d, 1);
        wr(5'h10, 16'h0008);
        wr(5'h14, 16'h7777);
        wait_idle(n);
        rd_entry(0, 0, d); check("R11", "tx entry in window kept", d, 16'h1111);
        rd_entry(0, 8, d); check("R11", "tx entry outside window written", d, 16'h7777);
        rd(5'h0C, d); check("R11", "collision flag", d[3], 1);
        check("R11", "irq from collision", irq, 1);
        rd_entry(16, 0, d); check("R3", "rx 16-bit with default size", d, 16'hEEEE);
        wr(5'h0C, 16'h000D);
    endtask

    task automatic t_div0();
        logic [15:0] d;
        int n;
        wr(5'h00, 16'hA000);
        load_entry(0, 16'h4000, 16'h00C3);
        wr(5'h08, 16'h0000);
        clr_mon();
        wr(5'h04, 16'h8000);
        repeat (60) @(negedge clk);
        check("R2", "no SCK edge with divisor 0", rises, 0);
        rd(5'h04, d); check("R2", "batch waits with divisor 0", d[15], 1);
        wr(5'h00, 16'hA002);
        wait_idle(n);
        check("R2", "batch resumes once divisor set", rises, 8);
        rd_entry(16, 0, d); check("R2", "rx after resume", d, 16'h003C);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_port();
        t_basic8();
        t_mode16();
        t_wrapwin();
        t_cs();
        t_gap();
        t_halt();
        t_loop();
        t_collision();
        t_div0();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule